// File: doc/BRIEF.md
# Direction-Aware Bus Arbiter

This block picks one winner per cycle among up to sixteen channels that compete for a single shared bus. Each request carries a direction bit that says whether it reads or writes. Channels have a fixed base priority: the lower the index, the stronger the claim. The arbiter favours requests that move in the same direction as the recent traffic, because this saves bus turnarounds. A request that runs against the favoured direction is ranked as if its index were sixteen higher. It still wins when no request in the favoured direction competes, so a pending request never leaves a cycle idle.

The favoured direction follows the traffic. It takes the direction of any granted transfer that goes against it. It is released when a cycle has no requests at all. It flips by itself once a programmable budget of same-direction grants is used up. This trades some waiting time for fewer direction changes on the bus. A budget of zero turns the preference off, and the arbiter is then plain fixed priority. Grants are registered one cycle after the requests are sampled. The grant, valid flag and favoured direction are plain control pins with no handshake: a requester treats a grant as its bus slot for that cycle.

Top module: `dirarb_top`

## Requirements
- R1: A synchronous active-high reset clears the grant vector and the valid flag, sets the favoured direction to read (0), and loads the budget counter from the period input.
- R2: The grant vector is one-hot or zero. It shows the result for the requests sampled at the previous clock edge, is a subset of those requests, and the valid flag is high exactly when at least one request was present.
- R3: Among requests that all go in the favoured direction, the lowest channel index wins.
- R4: A request whose direction bit (0 read, 1 write) differs from the favoured direction ranks at its index plus 16. A higher channel going with the traffic therefore beats a lower channel going against it.
- R5: When every pending request goes against the favoured direction, the lowest index among them still wins. A cycle with a request is never left without a grant.
- R6: A grant against the favoured direction makes that grant's direction the favoured one and reloads the budget counter from the period input.
- R7: Each grant in the favoured direction uses up one unit of budget. The grant that uses the last unit switches the favoured direction to its opposite and reloads the counter. With period P, P consecutive favoured grants cause the switch.
- R8: A cycle with no requests releases the preference and reloads the counter. The next arbitration applies no penalty, and its grant sets the favoured direction.
- R9: A period input of zero turns the penalty off, so the arbitration is pure fixed priority by index. The favoured-direction output then follows the direction of the most recent grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 16 | Request per channel |
| dir_i | input | 16 | Direction per channel, 0 read, 1 write |
| period_i | input | 8 | Budget of favoured-direction grants; 0 turns the preference off |
| gnt_o | output | 16 | One-hot grant, registered |
| gnt_vld_o | output | 1 | A grant is present in gnt_o |
| pref_dir_o | output | 1 | Currently favoured direction, 0 read, 1 write |

## Verification
The assertions assume that the request, direction and period inputs are known (never X) at every rising edge. They also assume the period input may change at any time, but that a new value takes effect only when the counter reloads. The assertions about grants look one edge into the past and therefore become active only after the first clock edge out of reset. The stimulus drives every input from the falling edge with fully defined values. It covers directed cases for each ranking and preference rule, followed by a long random sweep over request masks, direction masks and small period values that include zero.

// File: rtl/dirarb_pkg.sv
package dirarb_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;
endpackage

// File: rtl/dirarb_pick.sv
module dirarb_pick #(
  parameter int N_CH = 16
) (
  input  logic [N_CH-1:0]          req,
  input  logic [N_CH-1:0]          dir,
  input  logic                     pref,
  input  logic                     pen_en,
  output logic                     any,
  output logic [$clog2(N_CH)-1:0]  win,
  output logic                     win_dir
);
  localparam int IDX_W = $clog2(N_CH);
  localparam int PRI_W = IDX_W + 1;

  logic [PRI_W-1:0] best;
  logic [PRI_W-1:0] eff;
  logic             pen;

  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '1;
    eff  = '0;
    pen  = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      pen = pen_en && (dir[i] != pref);
      eff = {pen, IDX_W'(i)};
      if (req[i] && (!any || eff < best)) begin
        any  = 1'b1;
        best = eff;
        win  = IDX_W'(i);
      end
    end
    win_dir = dir[win];
  end
endmodule

// File: rtl/dirarb_flow.sv
module dirarb_flow
  import dirarb_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  input  logic             fire,
  input  logic             fire_dir,
  output logic             pref,
  output logic             pen_en
);
  logic [PER_W-1:0] cnt_q;
  logic             open_q;
  logic             pref_q;
  logic             live_q;

  assign pref   = pref_q;
  assign pen_en = (period != '0) && !open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pref_q <= DIR_RD;
      cnt_q  <= period;
      open_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (period == '0) begin
        if (fire) pref_q <= fire_dir;
        cnt_q  <= '0;
        open_q <= !fire;
      end else if (!fire) begin
        open_q <= 1'b1;
        cnt_q  <= period;
      end else if (open_q || fire_dir != pref_q) begin
        pref_q <= fire_dir;
        cnt_q  <= period;
        open_q <= 1'b0;
      end else if (cnt_q <= PER_W'(1)) begin
        pref_q <= ~pref_q;
        cnt_q  <= period;
      end else begin
        cnt_q  <= cnt_q - PER_W'(1);
      end
    end
  end

  AST_PREF_HOLD: assert property (@(posedge clk) disable iff (rst || !live_q)
    !$past(fire) && $past(period) != '0 |-> $stable(pref_q)); // R8
  AST_BUDGET_FLIP: assert property (@(posedge clk) disable iff (rst || !live_q)
    fire && !open_q && period != '0 && fire_dir == pref_q && cnt_q == PER_W'(1)
      |=> pref_q != $past(pref_q)); // R7
  AST_AGAINST_TAKES: assert property (@(posedge clk) disable iff (rst || !live_q)
    fire && fire_dir != pref_q |=> pref_q == $past(fire_dir)); // R6
endmodule

// File: rtl/dirarb_top.sv
module dirarb_top #(
  parameter int N_CH  = 16,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  req_i,
  input  logic [N_CH-1:0]  dir_i,
  input  logic [PER_W-1:0] period_i,
  output logic [N_CH-1:0]  gnt_o,
  output logic             gnt_vld_o,
  output logic             pref_dir_o
);
  localparam int IDX_W = $clog2(N_CH);

  logic             any;
  logic [IDX_W-1:0] win;
  logic             win_dir;
  logic             pref;
  logic             pen_en;
  logic [N_CH-1:0]  onehot;
  logic [N_CH-1:0]  gnt_q;
  logic             vld_q;
  logic             live_q;

  dirarb_pick #(.N_CH(N_CH)) pick_i (
    .req     (req_i),
    .dir     (dir_i),
    .pref    (pref),
    .pen_en  (pen_en),
    .any     (any),
    .win     (win),
    .win_dir (win_dir)
  );

  dirarb_flow #(.PER_W(PER_W)) flow_i (
    .clk      (clk),
    .rst      (rst),
    .period   (period_i),
    .fire     (any),
    .fire_dir (win_dir),
    .pref     (pref),
    .pen_en   (pen_en)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    assign onehot[g] = any && (win == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      vld_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      gnt_q  <= onehot;
      vld_q  <= any;
      live_q <= 1'b1;
    end
  end

  assign gnt_o      = gnt_q;
  assign gnt_vld_o  = vld_q;
  assign pref_dir_o = pref;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q)); // R2
  AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (rst || !live_q)
    (gnt_q & ~$past(req_i)) == '0); // R2
  AST_NO_IDLE: assert property (@(posedge clk) disable iff (rst || !live_q)
    vld_q == ($past(req_i) != '0)); // R5
  AST_FIXED_WHEN_OFF: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(period_i) == '0 |-> gnt_q == ($past(req_i) & (~$past(req_i) + 1'b1))); // R9
endmodule

// File: tb/dirarb_top_tb_top.sv
module dirarb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] req;
  logic [15:0] dir;
  logic [7:0]  period;
  logic [15:0] gnt;
  logic        gnt_vld;
  logic        pref_dir;

  int n_chk  = 0;
  int n_fail = 0;

  bit       m_pref;
  bit       m_open;
  int       m_cnt;

  always #2.5 clk = ~clk;

  dirarb_top #(.N_CH(16), .PER_W(8)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req),
    .dir_i      (dir),
    .period_i   (period),
    .gnt_o      (gnt),
    .gnt_vld_o  (gnt_vld),
    .pref_dir_o (pref_dir)
  );

  task automatic check(input string tag, input [15:0] eg, input bit ev, input bit ep);
    n_chk++;
    if (gnt !== eg || gnt_vld !== ev || pref_dir !== ep) begin
      n_fail++;
      $display("FAIL %s: gnt=%h vld=%b pref=%b expected gnt=%h vld=%b pref=%b",
               tag, gnt, gnt_vld, pref_dir, eg, ev, ep);
    end
  endtask

  task automatic step(input [15:0] r, input [15:0] d, input [7:0] p, input string tag);
    bit en;
    int best;
    int beste;
    int e;
    bit fire;
    bit bdir;
    logic [15:0] eg;
    en = (p != 0) && !m_open;
    best = -1;
    beste = 1000;
    for (int i = 0; i < 16; i++) begin
      if (r[i]) begin
        e = i + ((en && (d[i] != m_pref)) ? 16 : 0);
        if (e < beste) begin
          beste = e;
          best = i;
        end
      end
    end
    fire = (best >= 0);
    eg   = fire ? (16'h1 << best) : 16'h0;
    bdir = fire ? d[best] : 1'b0;
    if (p == 0) begin
      if (fire) m_pref = bdir;
      m_cnt  = 0;
      m_open = !fire;
    end else if (!fire) begin
      m_open = 1'b1;
      m_cnt  = p;
    end else if (m_open || bdir != m_pref) begin
      m_pref = bdir;
      m_cnt  = p;
      m_open = 1'b0;
    end else if (m_cnt <= 1) begin
      m_pref = !m_pref;
      m_cnt  = p;
    end else begin
      m_cnt  = m_cnt - 1;
    end
    req = r;
    dir = d;
    period = p;
    @(posedge clk);
    @(negedge clk);
    check(tag, eg, fire, m_pref);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    rst = 1'b1;
    req = '0;
    dir = '0;
    period = 8'd4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_pref = 1'b0;
    m_open = 1'b0;
    m_cnt  = 4;
    check("R1 reset state", 16'h0, 1'b0, 1'b0);

    step(16'b0000_0000_0010_1000, 16'h0000, 8'd4, "R3 same-direction lowest index");
    step(16'b0000_0000_0010_1000, 16'h0008, 8'd4, "R4 with-traffic ch5 beats against ch3");
    step(16'b0000_0000_0100_1000, 16'h0048, 8'd4, "R5 all against, ch3 wins; R6 pref to write");
    step(16'b0000_0000_0000_0010, 16'h0002, 8'd4, "R6 write now favoured");
    step(16'h0000, 16'h0000, 8'd3, "R8 idle cycle");
    step(16'h0004, 16'h0000, 8'd3, "R8 grant after idle sets pref read");
    step(16'h0004, 16'h0000, 8'd3, "R7 budget use 1");
    step(16'h0004, 16'h0000, 8'd3, "R7 budget use 2");
    step(16'h0004, 16'h0000, 8'd3, "R7 last unit flips pref to write");
    step(16'h0000, 16'h0000, 8'd3, "R8 idle releases preference");
    step(16'h0003, 16'h0002, 8'd3, "R8 no penalty after idle, ch0 read wins");
    step(16'h0210, 16'h0010, 8'd0, "R9 period zero fixed priority");
    step(16'h0220, 16'h0000, 8'd0, "R9 pref follows last grant");
    step(16'h8000, 16'h8000, 8'd2, "R5 single against request granted");

    for (int k = 0; k < 6000; k++) begin
      logic [15:0] r;
      logic [7:0]  p;
      r = 16'($urandom) & 16'($urandom);
      if (k % 7 == 0) r = '0;
      case (k % 5)
        0: p = 8'd0;
        1: p = 8'd1;
        2: p = 8'd2;
        3: p = 8'd3;
        default: p = 8'd5;
      endcase
      step(r, 16'($urandom), p, "R2 random sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule